// File: doc/BRIEF.md
# Multi-Digit Packed BCD Adder

This block adds two unsigned packed-BCD operands plus a one-bit carry-in and returns a packed-BCD sum and a decimal carry-out. It is purely combinational. Each four-bit group holds one decimal digit, and the least significant digit sits in bits [3:0]. The operand width is set by a digit-count parameter, and the default is four digits.

Every digit stage does two things. First it forms the plain binary sum of its two digits and its incoming decimal carry. It then applies a decimal correction. When that binary sum is above nine, the stage adds six and keeps only the low four bits as the result digit. The condition that triggers the correction also becomes the decimal carry into the next stage up.

The stages form a ripple chain. The carry from the top stage is the block's carry-out. Operands are assumed to hold valid digits only. Subtraction and complement forms are handled outside this block.

Top module: `bcd_adder`

## Requirements
- R1: Digits use codes 0000 to 1001 for the values 0 to 9. For valid operands, every digit of `sum_o` is in the range 0 to 9.
- R2: A stage whose binary sum (digit a + digit b + incoming carry) exceeds 9 outputs that sum plus 6, keeping only the low 4 bits. Any carry out of the +6 addition is dropped.
- R3: A stage's decimal carry is 1 exactly when one of these holds: its binary addition carried out of bit 3, or its 4-bit sum matches 11XX, or its 4-bit sum matches 1X1X. That carry is the carry-in of the next more significant stage.
- R4: Digits 5 and 8 with no carry-in produce digit 3 and a decimal carry of 1.
- R5: Digits 9 and 7 with no carry-in give binary 1 0000. The stage produces digit 6 and a decimal carry of 1.
- R6: As a decimal number, `{cout_o, sum_o}` equals the decimal value of `a_i` plus that of `b_i` plus `cin_i`. `cout_o` is 1 exactly when that total is 10^NUM_DIGITS or more.
- R7: `cin_i` adds one at the least significant digit. An all-nines `a_i` with a zero `b_i` and `cin_i`=1 gives an all-zero `sum_o` and `cout_o`=1.
- R8: A stage whose binary sum is 9 or less passes that sum through unchanged and gives a decimal carry of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4*NUM_DIGITS | First packed-BCD operand, least significant digit in bits [3:0] |
| b_i | input | 4*NUM_DIGITS | Second packed-BCD operand |
| cin_i | input | 1 | Carry into the least significant digit |
| sum_o | output | 4*NUM_DIGITS | Packed-BCD sum |
| cout_o | output | 1 | Decimal carry out of the most significant digit |

## Verification
The assertions rely on every operand digit being in the range 0 to 9. The checker computes that condition itself and applies the arithmetic properties only when it holds, since out-of-range codes have no defined decimal meaning. Every stimulus task builds its operands digit by digit from values 0 to 9, so each applied vector stays inside that condition.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_digit_t;
  localparam bcd_digit_t DEC_ADJ = 4'd6;
endpackage

// File: rtl/bcd_digit_bin_add.sv
module bcd_digit_bin_add
  import bcd_add_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       c_i,
  output bcd_digit_t sum_o,
  output logic       co_o
);
  assign {co_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, c_i};
endmodule

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix
  import bcd_add_pkg::*;
(
  input  bcd_digit_t bin_sum_i,
  input  logic       bin_co_i,
  output bcd_digit_t dig_o,
  output logic       dc_o
);
  logic need_adj;

  // above nine: binary carry, or 11XX / 1X1X
  assign need_adj = bin_co_i | (bin_sum_i[3] & bin_sum_i[2]) | (bin_sum_i[3] & bin_sum_i[1]);
  // carry of the +6 step is dropped by the 4-bit result
  assign dig_o    = bin_sum_i + (need_adj ? DEC_ADJ : bcd_digit_t'(0));
  assign dc_o     = need_adj;
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_add_pkg::*;
(
  input  bcd_digit_t a_i,
  input  bcd_digit_t b_i,
  input  logic       c_i,
  output bcd_digit_t dig_o,
  output logic       dc_o
);
  bcd_digit_t bin_sum;
  logic       bin_co;

  bcd_digit_bin_add u_bin (
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (c_i),
    .sum_o(bin_sum),
    .co_o (bin_co)
  );

  bcd_digit_fix u_fix (
    .bin_sum_i(bin_sum),
    .bin_co_i (bin_co),
    .dig_o    (dig_o),
    .dc_o     (dc_o)
  );
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic [DIGIT_W*NUM_DIGITS-1:0] a_i,
  input  logic [DIGIT_W*NUM_DIGITS-1:0] b_i,
  input  logic                          cin_i,
  output logic [DIGIT_W*NUM_DIGITS-1:0] sum_o,
  output logic                          cout_o
);
  localparam int VEC_W = DIGIT_W * NUM_DIGITS;

  logic [NUM_DIGITS:0] dcarry;

  assign dcarry[0] = cin_i;

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    bcd_digit_stage u_stage (
      .a_i  (a_i[d*DIGIT_W +: DIGIT_W]),
      .b_i  (b_i[d*DIGIT_W +: DIGIT_W]),
      .c_i  (dcarry[d]),
      .dig_o(sum_o[d*DIGIT_W +: DIGIT_W]),
      .dc_o (dcarry[d+1])
    );
  end

  assign cout_o = dcarry[NUM_DIGITS];

  logic unused_w;
  assign unused_w = ^{VEC_W[0]};
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic [4*NUM_DIGITS-1:0] a_i,
  input logic [4*NUM_DIGITS-1:0] b_i,
  input logic                    cin_i,
  input logic [4*NUM_DIGITS-1:0] sum_o,
  input logic                    cout_o
);
  function automatic longint dec_val(logic [4*NUM_DIGITS-1:0] v);
    longint r = 0;
    for (int i = NUM_DIGITS - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic all_valid(logic [4*NUM_DIGITS-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  function automatic longint pow10_n();
    longint p = 1;
    for (int i = 0; i < NUM_DIGITS; i++) p = p * 10;
    return p;
  endfunction

  function automatic logic all_nines(logic [4*NUM_DIGITS-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (v[i*4 +: 4] != 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic   in_ok;
  longint total;
  int     low_bin;

  always_comb begin
    in_ok   = all_valid(a_i) && all_valid(b_i);
    total   = dec_val(a_i) + dec_val(b_i) + longint'(cin_i);
    low_bin = int'(a_i[3:0]) + int'(b_i[3:0]) + int'(cin_i);
    if (in_ok) begin
      // R1
      digit_range_chk: assert (all_valid(sum_o));
      // R6
      decimal_total_chk: assert (dec_val(sum_o) + (cout_o ? pow10_n() : 64'd0) == total);
      // R6
      carry_out_chk: assert (cout_o == (total >= pow10_n()));
      // R8
      if (low_bin <= 9) begin
        low_passthru_chk: assert (int'(sum_o[3:0]) == low_bin);
      end
      // R2
      if (low_bin > 9) begin
        low_adjust_chk: assert (sum_o[3:0] == 4'(low_bin + 6));
      end
      // R7
      if (cin_i && all_nines(a_i) && b_i == '0) begin
        wrap_all_chk: assert (sum_o == '0 && cout_o);
      end
    end
  end
endmodule

bind bcd_adder bcd_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o)
);

// File: tb/bcd_adder_tb.sv
module bcd_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int W = 4 * ND;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           n_vec = 0;
  int           n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adder #(.NUM_DIGITS(ND)) u_dut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  function automatic longint to_dec(logic [W-1:0] v);
    longint r = 0;
    for (int i = ND - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] to_bcd(longint v);
    logic [W-1:0] r = '0;
    longint t = v;
    for (int i = 0; i < ND; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic longint lim();
    longint p = 1;
    for (int i = 0; i < ND; i++) p = p * 10;
    return p;
  endfunction

  // drive on falling edge, sample a quarter period later
  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic c,
                       input string tag);
    longint       tot;
    logic [W-1:0] exp_s;
    logic         exp_c;
    @(negedge clk);
    a = av; b = bv; cin = c;
    tot   = to_dec(av) + to_dec(bv) + longint'(c);
    exp_c = tot >= lim();
    exp_s = to_bcd(tot % lim());
    #(CLK_PERIOD/4);
    n_vec++;
    if (sum !== exp_s || cout !== exp_c) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b exp sum=%h cout=%0b",
               tag, av, bv, c, sum, cout, exp_s, exp_c);
    end
  endtask

  task automatic t_idle;
    apply('0, '0, 1'b0, "R1 idle zero");
  endtask

  // every digit pair with both carries, at lowest and highest position
  task automatic t_single_digit;
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++)
        for (int c = 0; c < 2; c++) begin
          logic [W-1:0] av = '0, bv = '0;
          av[3:0] = 4'(x); bv[3:0] = 4'(y);
          apply(av, bv, 1'(c), (x + y + c > 9) ? "R2 R3 adjust low" : "R8 pass low");
          av = '0; bv = '0;
          av[W-1 -: 4] = 4'(x); bv[W-1 -: 4] = 4'(y);
          apply(av, bv, 1'(c), "R3 R6 top digit");
        end
  endtask

  task automatic t_named_cases;
    apply(16'h0005, 16'h0008, 1'b0, "R4 five plus eight");
    apply(16'h0009, 16'h0007, 1'b0, "R5 nine plus seven");
    apply(16'h0050, 16'h0080, 1'b0, "R4 five plus eight mid");
    apply(16'h0900, 16'h0700, 1'b0, "R5 nine plus seven mid");
    apply(16'h0009, 16'h0009, 1'b1, "R2 max digit sum");
  endtask

  task automatic t_ripple;
    apply(16'h9999, 16'h0000, 1'b1, "R7 full wrap");
    apply(16'h0095, 16'h0005, 1'b0, "R3 two-stage ripple");
    apply(16'h0999, 16'h0000, 1'b1, "R7 partial ripple");
    apply(16'h9999, 16'h9999, 1'b1, "R6 max operands");
    apply(16'h4545, 16'h5454, 1'b0, "R8 all nine no carry");
    apply(16'h4545, 16'h5454, 1'b1, "R3 carry through nines");
  endtask

  task automatic t_random;
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] av, bv;
      for (int d = 0; d < ND; d++) begin
        av[d*4 +: 4] = 4'($urandom_range(0, 9));
        bv[d*4 +: 4] = 4'($urandom_range(0, 9));
      end
      apply(av, bv, 1'($urandom_range(0, 1)), "R6 R1 random");
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    t_idle();
    t_single_digit();
    t_named_cases();
    t_ripple();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule